// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block is the command front end of a byte-wide parallel NOR flash. It watches host write cycles, formed by chip enable and write enable with address and data, and steps through multi-write unlock sequences. A completed sequence starts a self-timed program or erase operation on a behavioural array. The array is divided into equal sectors. The block also offers a shortcut program mode that needs only two writes per byte. An erase that is running can be suspended and resumed, and a per-sector protect input shields sectors from change. A hardware reset input aborts whatever is in progress.

Reads need no command. `rdata` always shows the array byte at `addr`. `rdy` is low while an embedded operation runs. The busy times stand in for the embedded algorithms and are parameters counted in clock cycles. The geometry is also set by parameters: `SECT_CNT` sectors of 2^`SECT_AW` bytes each. With 64 sectors and a 16-bit offset, the byte address is 22 bits wide. The small defaults keep the behavioural array light.

Top module: `flash_cmd_top`

## Requirements
- R1: After power-on reset (`rst_n` low), every array byte reads 0xFF and `rdy` is high.
- R2: A write cycle is counted once for each fall of (`ce_n` OR `we_n`). The unlock writes use data 0xAA and then 0x55, at any address. They are followed by the command 0xA0 and then a fourth write whose address and data give the byte to program.
- R3: A program can only clear bits. The stored byte becomes old AND written data.
- R4: `rdy` goes low for exactly `PGM_CYC` cycles for a program. For an erase it goes low for exactly `ERS_CYC` cycles, not counting time spent suspended.
- R5: A write that does not match the expected step returns the sequencer to read mode. Writes in read mode other than 0xAA change nothing.
- R6: The sequence 0xAA, 0x55, 0x20 enters a shortcut mode. In that mode each program is 0xA0 followed by one address/data write, and the sequencer stays in the mode after each program. Any other write leaves the mode for read mode.
- R7: The sequence 0xAA, 0x55, 0x80, 0xAA, 0x55, 0x30 selects the sector given by the upper address bits (sector = addr >> `SECT_AW`). Each further 0x30 write within `ERS_WIN` cycles adds a sector and restarts the window. When the window lapses, all selected sectors are set to 0xFF. Sectors that were not selected keep their data.
- R8: The sequence with 0x10 as the final byte erases every unprotected sector. The erase starts at once.
- R9: When bit s of `sect_prot` is set, sector s ignores both program and erase. A program aimed at it never makes `rdy` go low. The protect bits are held stable while an operation runs.
- R10: A 0xB0 write during an erase suspends it: `rdy` goes high and the erase time stops counting. While suspended, reads work and a full unlock program to a sector that is not being erased runs. A program aimed at a sector being erased is ignored. A 0x30 write resumes the erase.
- R11: Driving `hw_rst_n` low aborts any operation. The targeted bytes are left unchanged, `rdy` returns high and the sequencer returns to read mode, leaving the shortcut mode if it was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous; also erases the array |
| hw_rst_n | input | 1 | Hardware abort, active low; array contents are kept |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Byte address {sector, offset} |
| wdata | input | 8 | Write data / command byte |
| sect_prot | input | SECT_CNT | Per-sector protect bits |
| rdata | output | 8 | Array byte at `addr` |
| rdy | output | 1 | High when no embedded operation is running |

## Verification
The hardest case to reach is a program issued while an erase is suspended. The stimulus has to start a sector erase, let the selection window lapse, and land the 0xB0 write while `rdy` is low. Only then can it issue a full unlock program to a different sector, and a second one to the sector being erased. The bench counts the cycles that `rdy` is low over the whole episode and expects the erase time plus one program time. This shows the erase time stopped counting during the suspension. The bench also reads the erasing sector before the resume to confirm that it still holds its old data and that the blocked program left it untouched.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [4:0] {
    ST_READ, ST_U1, ST_U2, ST_PGM_DATA, ST_PGM_BUSY,
    ST_ERS_SET, ST_ERS_U1, ST_ERS_U2, ST_ERS_WIN, ST_ERS_BUSY,
    ST_SUSP, ST_SU1, ST_SU2, ST_SPGM_DATA, ST_SPGM_BUSY,
    ST_BYP, ST_BYP_DATA, ST_BPGM_BUSY
  } seq_state_e;

  localparam logic [7:0] CMD_UNL1   = 8'hAA;
  localparam logic [7:0] CMD_UNL2   = 8'h55;
  localparam logic [7:0] CMD_PGM    = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_BYPASS = 8'h20;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          stb_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  logic wr_low, wr_low_q, hit;

  assign wr_low = !(ce_n | we_n);
  assign hit    = wr_low && !wr_low_q && hw_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_q <= 1'b0;
      stb_o    <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
    end else begin
      wr_low_q <= wr_low;
      stb_o    <= hit;
      if (hit) begin
        addr_o <= addr;
        data_o <= wdata;
      end
    end
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt, cnt_n;
  logic          act, act_n;

  assign done = act && run && (cnt == CW'(CYC - 1));

  always_comb begin
    act_n = act;
    cnt_n = cnt;
    if (clr) begin
      act_n = 1'b0;
      cnt_n = '0;
    end else if (start) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else if (done) begin
      act_n = 1'b0;
    end else if (act && run) begin
      cnt_n = cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else begin
      act <= act_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int SECT_CNT = 8,
  parameter int SECT_AW  = 4,
  parameter int AW       = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_rst_n,
  input  logic                stb,
  input  logic [AW-1:0]       a,
  input  logic [7:0]          d,
  input  logic [SECT_CNT-1:0] sect_prot,
  input  logic                pgm_done,
  input  logic                ers_done,
  input  logic                win_done,
  output logic                pgm_start,
  output logic                pgm_run,
  output logic                ers_start,
  output logic                ers_run,
  output logic                win_start,
  output logic                win_run,
  output logic [AW-1:0]       op_addr,
  output logic [7:0]          op_data,
  output logic [SECT_CNT-1:0] ers_mask,
  output logic                rdy
);
  localparam int SW = AW - SECT_AW;

  seq_state_e          st, st_n;
  logic [AW-1:0]       op_addr_n;
  logic [7:0]          op_data_n;
  logic [SECT_CNT-1:0] mask_n, sel_1h;
  logic [SW-1:0]       sec;
  logic                prot_hit;

  assign sec      = a[AW-1:SECT_AW];
  assign sel_1h   = SECT_CNT'(1) << sec;
  assign prot_hit = sect_prot[sec];

  assign pgm_run = (st == ST_PGM_BUSY) || (st == ST_SPGM_BUSY) || (st == ST_BPGM_BUSY);
  assign ers_run = (st == ST_ERS_BUSY);
  assign win_run = (st == ST_ERS_WIN);
  assign rdy     = !(pgm_run || ers_run);

  always_comb begin
    st_n      = st;
    op_addr_n = op_addr;
    op_data_n = op_data;
    mask_n    = ers_mask;
    pgm_start = 1'b0;
    ers_start = 1'b0;
    win_start = 1'b0;
    unique case (st)
      ST_READ:   if (stb && d == CMD_UNL1) st_n = ST_U1;
      ST_U1:     if (stb) st_n = (d == CMD_UNL2) ? ST_U2 : ST_READ;
      ST_U2:     if (stb) begin
                   unique case (d)
                     CMD_PGM:    st_n = ST_PGM_DATA;
                     CMD_ESETUP: st_n = ST_ERS_SET;
                     CMD_BYPASS: st_n = ST_BYP;
                     default:    st_n = ST_READ;
                   endcase
                 end
      ST_PGM_DATA: if (stb) begin
                   if (!prot_hit) begin
                     op_addr_n = a;
                     op_data_n = d;
                     pgm_start = 1'b1;
                     st_n      = ST_PGM_BUSY;
                   end else st_n = ST_READ;
                 end
      ST_PGM_BUSY: if (pgm_done) st_n = ST_READ;
      ST_ERS_SET: if (stb) st_n = (d == CMD_UNL1) ? ST_ERS_U1 : ST_READ;
      ST_ERS_U1:  if (stb) st_n = (d == CMD_UNL2) ? ST_ERS_U2 : ST_READ;
      ST_ERS_U2:  if (stb) begin
                   if (d == CMD_SECT) begin
                     mask_n    = sel_1h & ~sect_prot;
                     win_start = 1'b1;
                     st_n      = ST_ERS_WIN;
                   end else if (d == CMD_CHIP && (~sect_prot != '0)) begin
                     mask_n    = ~sect_prot;
                     ers_start = 1'b1;
                     st_n      = ST_ERS_BUSY;
                   end else st_n = ST_READ;
                 end
      ST_ERS_WIN: if (stb) begin
                   if (d == CMD_SECT) begin
                     mask_n    = ers_mask | (sel_1h & ~sect_prot);
                     win_start = 1'b1;
                   end else begin
                     mask_n = '0;
                     st_n   = ST_READ;
                   end
                 end else if (win_done) begin
                   if (ers_mask != '0) begin
                     ers_start = 1'b1;
                     st_n      = ST_ERS_BUSY;
                   end else st_n = ST_READ;
                 end
      ST_ERS_BUSY: if (ers_done) begin
                   mask_n = '0;
                   st_n   = ST_READ;
                 end else if (stb && d == CMD_SUSP) st_n = ST_SUSP;
      ST_SUSP:   if (stb) begin
                   if (d == CMD_UNL1) st_n = ST_SU1;
                   else if (d == CMD_RESUME) st_n = ST_ERS_BUSY;
                 end
      ST_SU1:    if (stb) st_n = (d == CMD_UNL2) ? ST_SU2 : ST_SUSP;
      ST_SU2:    if (stb) st_n = (d == CMD_PGM) ? ST_SPGM_DATA : ST_SUSP;
      ST_SPGM_DATA: if (stb) begin
                   if (!prot_hit && !ers_mask[sec]) begin
                     op_addr_n = a;
                     op_data_n = d;
                     pgm_start = 1'b1;
                     st_n      = ST_SPGM_BUSY;
                   end else st_n = ST_SUSP;
                 end
      ST_SPGM_BUSY: if (pgm_done) st_n = ST_SUSP;
      ST_BYP:    if (stb) st_n = (d == CMD_PGM) ? ST_BYP_DATA : ST_READ;
      ST_BYP_DATA: if (stb) begin
                   if (!prot_hit) begin
                     op_addr_n = a;
                     op_data_n = d;
                     pgm_start = 1'b1;
                     st_n      = ST_BPGM_BUSY;
                   end else st_n = ST_BYP;
                 end
      ST_BPGM_BUSY: if (pgm_done) st_n = ST_BYP;
      default:   st_n = ST_READ;
    endcase
    if (!hw_rst_n) begin
      st_n      = ST_READ;
      mask_n    = '0;
      pgm_start = 1'b0;
      ers_start = 1'b0;
      win_start = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_READ;
      op_addr  <= '0;
      op_data  <= '0;
      ers_mask <= '0;
    end else begin
      st       <= st_n;
      op_addr  <= op_addr_n;
      op_data  <= op_data_n;
      ers_mask <= mask_n;
    end
  end
endmodule

// File: rtl/flash_sector_array.sv
module flash_sector_array #(
  parameter int SECT_CNT = 8,
  parameter int SECT_AW  = 4,
  parameter int AW       = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       rd_addr,
  input  logic                pgm_en,
  input  logic [AW-1:0]       pgm_addr,
  input  logic [7:0]          pgm_data,
  input  logic                ers_en,
  input  logic [SECT_CNT-1:0] ers_mask,
  output logic [7:0]          rdata
);
  localparam int SECT_BYTES = 1 << SECT_AW;
  localparam int SW         = AW - SECT_AW;

  logic [7:0]         sect_rd [SECT_CNT];
  logic [SW-1:0]      rd_sec, pg_sec;
  logic [SECT_AW-1:0] rd_off, pg_off;

  assign rd_sec = rd_addr[AW-1:SECT_AW];
  assign rd_off = rd_addr[SECT_AW-1:0];
  assign pg_sec = pgm_addr[AW-1:SECT_AW];
  assign pg_off = pgm_addr[SECT_AW-1:0];

  for (genvar s = 0; s < SECT_CNT; s++) begin : g_sect
    logic [7:0] mem [SECT_BYTES];
    logic       wipe, prog;

    assign wipe       = ers_en && ers_mask[s];
    assign prog       = pgm_en && (pg_sec == SW'(s));
    assign sect_rd[s] = mem[rd_off];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < SECT_BYTES; i++) mem[i] <= 8'hFF;
      end else if (wipe) begin
        for (int i = 0; i < SECT_BYTES; i++) mem[i] <= 8'hFF;
      end else if (prog) begin
        mem[pg_off] <= mem[pg_off] & pgm_data;
      end
    end
  end

  assign rdata = sect_rd[rd_sec];
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top #(
  parameter int SECT_CNT = 8,
  parameter int SECT_AW  = 4,
  parameter int PGM_CYC  = 6,
  parameter int ERS_CYC  = 20,
  parameter int ERS_WIN  = 8,
  parameter int AW       = $clog2(SECT_CNT) + SECT_AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hw_rst_n,
  input  logic                ce_n,
  input  logic                we_n,
  input  logic [AW-1:0]       addr,
  input  logic [7:0]          wdata,
  input  logic [SECT_CNT-1:0] sect_prot,
  output logic [7:0]          rdata,
  output logic                rdy
);
  logic                wr_stb;
  logic [AW-1:0]       wr_addr, op_addr;
  logic [7:0]          wr_data, op_data;
  logic                pgm_start, pgm_run, pgm_done;
  logic                ers_start, ers_run, ers_done;
  logic                win_start, win_run, win_done;
  logic [SECT_CNT-1:0] ers_mask;
  logic                pgm_commit, ers_commit;

  assign pgm_commit = pgm_done && hw_rst_n;
  assign ers_commit = ers_done && hw_rst_n;

  flash_wr_capture #(.AW(AW)) i_cap (
    .clk, .rst_n, .hw_rst_n, .ce_n, .we_n, .addr, .wdata,
    .stb_o(wr_stb), .addr_o(wr_addr), .data_o(wr_data)
  );

  flash_seq_ctrl #(.SECT_CNT(SECT_CNT), .SECT_AW(SECT_AW), .AW(AW)) i_seq (
    .clk, .rst_n, .hw_rst_n, .stb(wr_stb), .a(wr_addr), .d(wr_data), .sect_prot,
    .pgm_done, .ers_done, .win_done, .pgm_start, .pgm_run, .ers_start, .ers_run,
    .win_start, .win_run, .op_addr, .op_data, .ers_mask, .rdy
  );

  flash_op_timer #(.CYC(PGM_CYC)) i_pgm_tmr (
    .clk, .rst_n, .clr(!hw_rst_n), .start(pgm_start), .run(pgm_run), .done(pgm_done)
  );

  flash_op_timer #(.CYC(ERS_CYC)) i_ers_tmr (
    .clk, .rst_n, .clr(!hw_rst_n), .start(ers_start), .run(ers_run), .done(ers_done)
  );

  flash_op_timer #(.CYC(ERS_WIN)) i_win_tmr (
    .clk, .rst_n, .clr(!hw_rst_n), .start(win_start), .run(win_run), .done(win_done)
  );

  flash_sector_array #(.SECT_CNT(SECT_CNT), .SECT_AW(SECT_AW), .AW(AW)) i_arr (
    .clk, .rst_n, .rd_addr(addr), .pgm_en(pgm_commit), .pgm_addr(op_addr),
    .pgm_data(op_data), .ers_en(ers_commit), .ers_mask, .rdata
  );
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int SECT_CNT = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hw_rst_n,
  input logic                rdy,
  input logic                wr_stb,
  input logic                win_done,
  input logic                pgm_commit,
  input logic                ers_commit,
  input logic [SECT_CNT-1:0] ers_mask,
  input logic [SECT_CNT-1:0] sect_prot
);
  AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |=> rdy); // R11

  AST_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_commit || ers_commit) |-> !rdy); // R4

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_commit && ers_commit)); // R4

  AST_ERASE_SKIPS_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    ers_commit |-> ((ers_mask & sect_prot) == '0)); // R9

  AST_BUSY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> ($past(wr_stb) || $past(win_done))); // R2

  AST_READY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(pgm_commit || ers_commit || wr_stb || !hw_rst_n)); // R10
endmodule

bind flash_cmd_top flash_cmd_chk #(.SECT_CNT(SECT_CNT)) i_chk (
  .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .rdy(rdy), .wr_stb(wr_stb),
  .win_done(win_done), .pgm_commit(pgm_commit), .ers_commit(ers_commit),
  .ers_mask(ers_mask), .sect_prot(sect_prot)
);

// File: tb/test_flash_cmd_top.sv
module test_flash_cmd_top;
  localparam int SECT_CNT = 8;
  localparam int SECT_AW  = 4;
  localparam int PGM_CYC  = 6;
  localparam int ERS_CYC  = 20;
  localparam int ERS_WIN  = 8;
  localparam int AW       = 7;

  logic                clk = 1'b0;
  logic                rst_n, hw_rst_n, ce_n, we_n;
  logic [AW-1:0]       addr;
  logic [7:0]          wdata, rdata;
  logic [SECT_CNT-1:0] sect_prot;
  logic                rdy;

  int n_tests = 0;
  int n_fail  = 0;
  int lowcnt  = 0;

  typedef struct {
    bit         is_rdy;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #10 clk = ~clk;

  flash_cmd_top #(.SECT_CNT(SECT_CNT), .SECT_AW(SECT_AW), .PGM_CYC(PGM_CYC),
                  .ERS_CYC(ERS_CYC), .ERS_WIN(ERS_WIN), .AW(AW)) i_flash_cmd_top (
    .clk, .rst_n, .hw_rst_n, .ce_n, .we_n, .addr, .wdata, .sect_prot, .rdata, .rdy
  );

  task automatic chk(input string tag, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  always begin
    @(negedge clk);
    #5;
    while (sbq.size() > 0) begin
      sb_item_t it;
      it = sbq.pop_front();
      n_tests++;
      if (it.is_rdy) begin
        if (rdy !== it.exp[0]) begin
          n_fail++;
          $display("FAIL %s: rdy actual=%b expected=%b", it.tag, rdy, it.exp[0]);
        end
      end else if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rdata actual=%h expected=%h", it.tag, rdata, it.exp);
      end
    end
  end

  always begin
    @(negedge clk);
    #2;
    if (!rdy) lowcnt++;
  end

  task automatic exp_rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    sb_item_t it;
    @(negedge clk);
    addr = a;
    it.is_rdy = 1'b0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic exp_rdy(input logic e, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.is_rdy = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic seq_pgm(input logic [AW-1:0] a, input logic [7:0] d);
    bus_wr(7'h55, 8'hAA);
    bus_wr(7'h2A, 8'h55);
    bus_wr(7'h00, 8'hA0);
    bus_wr(a, d);
  endtask

  task automatic unlock_erase();
    bus_wr(7'h00, 8'hAA); bus_wr(7'h00, 8'h55); bus_wr(7'h00, 8'h80);
    bus_wr(7'h00, 8'hAA); bus_wr(7'h00, 8'h55);
  endtask

  task automatic idle_wait(input int lead);
    repeat (lead) @(negedge clk);
    for (int i = 0; i < 1000 && !rdy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int c0;
    rst_n = 1'b0; hw_rst_n = 1'b1; ce_n = 1'b1; we_n = 1'b1;
    addr = '0; wdata = '0; sect_prot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    exp_rdy(1'b1, "R1 ready after reset");
    exp_rd(7'h00, 8'hFF, "R1 erased at reset");
    exp_rd(7'h7F, 8'hFF, "R1 erased at reset");

    // R2 / R4 four-write program
    c0 = lowcnt;
    seq_pgm(7'h05, 8'h3C);
    idle_wait(2);
    chk("R4 program busy cycles", lowcnt - c0, PGM_CYC);
    exp_rd(7'h05, 8'h3C, "R2 programmed byte");

    // R3 AND semantics
    seq_pgm(7'h05, 8'hF0);
    idle_wait(2);
    exp_rd(7'h05, 8'h30, "R3 bits only cleared");

    // R5 mismatch
    c0 = lowcnt;
    bus_wr(7'h00, 8'hAA); bus_wr(7'h00, 8'h12);
    bus_wr(7'h06, 8'hA0); bus_wr(7'h06, 8'h00);
    bus_wr(7'h00, 8'hAA); bus_wr(7'h00, 8'h55); bus_wr(7'h00, 8'h77);
    bus_wr(7'h07, 8'h00);
    repeat (4) @(negedge clk);
    chk("R5 no busy after bad sequence", lowcnt - c0, 0);
    exp_rd(7'h06, 8'hFF, "R5 bad step ignored");
    exp_rd(7'h07, 8'hFF, "R5 bad command ignored");

    // R6 shortcut mode
    c0 = lowcnt;
    bus_wr(7'h00, 8'hAA); bus_wr(7'h00, 8'h55); bus_wr(7'h00, 8'h20);
    bus_wr(7'h10, 8'hA0); bus_wr(7'h10, 8'h5A); idle_wait(2);
    bus_wr(7'h11, 8'hA0); bus_wr(7'h11, 8'h81); idle_wait(2);
    chk("R6 two shortcut programs busy", lowcnt - c0, 2 * PGM_CYC);
    bus_wr(7'h00, 8'hF0);
    bus_wr(7'h12, 8'hA0); bus_wr(7'h12, 8'h00);
    repeat (4) @(negedge clk);
    exp_rd(7'h10, 8'h5A, "R6 shortcut program 1");
    exp_rd(7'h11, 8'h81, "R6 shortcut program 2");
    exp_rd(7'h12, 8'hFF, "R6 left shortcut mode");

    // preload
    seq_pgm(7'h20, 8'h77); idle_wait(2);
    seq_pgm(7'h30, 8'h11); idle_wait(2);
    seq_pgm(7'h40, 8'h12); idle_wait(2);

    // R9 protected program
    sect_prot = 8'b0000_0100;
    c0 = lowcnt;
    seq_pgm(7'h21, 8'h00);
    repeat (4) @(negedge clk);
    chk("R9 protected program not busy", lowcnt - c0, 0);
    exp_rd(7'h21, 8'hFF, "R9 protected byte kept");

    // R7 multi-sector erase with a protected member
    c0 = lowcnt;
    unlock_erase();
    bus_wr(7'h05, 8'h30); bus_wr(7'h30, 8'h30); bus_wr(7'h20, 8'h30);
    idle_wait(ERS_WIN + 4);
    chk("R4 sector erase busy cycles", lowcnt - c0, ERS_CYC);
    exp_rd(7'h05, 8'hFF, "R7 sector 0 erased");
    exp_rd(7'h30, 8'hFF, "R7 sector 3 erased");
    exp_rd(7'h10, 8'h5A, "R7 unselected sector kept");
    exp_rd(7'h40, 8'h12, "R7 unselected sector kept");
    exp_rd(7'h20, 8'h77, "R9 protected sector not erased");

    // R10 suspend / resume
    c0 = lowcnt;
    unlock_erase();
    bus_wr(7'h40, 8'h30);
    repeat (ERS_WIN + 6) @(negedge clk);
    bus_wr(7'h00, 8'hB0);
    repeat (2) @(negedge clk);
    exp_rdy(1'b1, "R10 ready while suspended");
    exp_rd(7'h40, 8'h12, "R10 erasing sector still readable");
    seq_pgm(7'h50, 8'h3E); idle_wait(2);
    seq_pgm(7'h40, 8'h00);
    repeat (4) @(negedge clk);
    exp_rd(7'h50, 8'h3E, "R10 program during suspend");
    exp_rd(7'h40, 8'h12, "R10 program to erasing sector ignored");
    bus_wr(7'h00, 8'h30);
    idle_wait(2);
    chk("R10 erase time excludes suspension", lowcnt - c0, ERS_CYC + PGM_CYC);
    exp_rd(7'h40, 8'hFF, "R10 erase finished after resume");
    exp_rd(7'h50, 8'h3E, "R10 other sector kept");

    // R8 chip erase
    c0 = lowcnt;
    unlock_erase();
    bus_wr(7'h00, 8'h10);
    idle_wait(2);
    chk("R8 chip erase busy cycles", lowcnt - c0, ERS_CYC);
    exp_rd(7'h50, 8'hFF, "R8 chip erase");
    exp_rd(7'h11, 8'hFF, "R8 chip erase");
    exp_rd(7'h20, 8'h77, "R8 protected sector kept");

    // R11 hardware abort
    sect_prot = '0;
    seq_pgm(7'h60, 8'h00);
    repeat (3) @(negedge clk);
    hw_rst_n = 1'b0;
    @(negedge clk);
    hw_rst_n = 1'b1;
    exp_rdy(1'b1, "R11 ready after abort");
    repeat (PGM_CYC + 2) @(negedge clk);
    exp_rd(7'h60, 8'hFF, "R11 aborted program left byte");
    seq_pgm(7'h60, 8'h0F); idle_wait(2);
    exp_rd(7'h60, 8'h0F, "R11 read mode after abort");
    bus_wr(7'h00, 8'hAA); bus_wr(7'h00, 8'h55); bus_wr(7'h00, 8'h20);
    @(negedge clk); hw_rst_n = 1'b0;
    @(negedge clk); hw_rst_n = 1'b1;
    bus_wr(7'h61, 8'hA0); bus_wr(7'h61, 8'h00);
    repeat (4) @(negedge clk);
    exp_rd(7'h61, 8'hFF, "R11 abort leaves shortcut mode");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule